// File: doc/BRIEF.md
# Instruction-Cycle Trace Buffer

This block records one 44-bit snapshot of the processor's program counter, data bus, two I/O ports and status lines for every instruction cycle that runs while emulation is active. Records go into a 255-entry circular store. Once the store has taken 255 records, each new record replaces the oldest one. While emulation is halted, capture stops and the write position holds still.

After a halt, the host walks a logical index from 0 upward. Index 0 always returns the oldest record still held, and the highest valid index returns the newest. Alongside the store runs a 16-bit instruction-cycle timer. It counts captured cycles, saturates at its maximum, and is zeroed by a host clear strobe.

Top module: `cycle_trace_buf`

## Requirements
- R1: After reset, `fill_o` is 0, `full_o` is 0, `cyc_cnt_o` is 0 and `rd_valid_o` is 0.
- R2: At each rising clock edge where `run_i` and `cyc_i` are both high, one record is stored. A record is laid out as bits [11:0] program counter, [19:12] data, [27:20] port A, [35:28] port B and [43:36] status. Each such capture raises `fill_o` by one until it reaches 255.
- R3: When `run_i` or `cyc_i` is low at an edge, nothing is stored. `fill_o`, the write position and all stored records stay unchanged, whatever the other inputs do.
- R4: The write position runs 0 to 254 and then returns to 0. `full_o` rises on the capture that completes the 255th record and stays high until reset. From that point `fill_o` holds at 255.
- R5: Read index 0 returns the oldest held record and index `fill_o`-1 the newest. After wrap-around, index k returns the record captured k places after the oldest surviving one.
- R6: `rd_data_o` and `rd_valid_o` are registered. They show the result for the `rd_idx_i` value sampled at the previous rising edge.
- R7: `rd_valid_o` is high exactly when the sampled index is below the `fill_o` value at that edge. An index of 255 is never valid.
- R8: `cyc_cnt_o` rises by one at every capture edge and saturates at 65535.
- R9: `cnt_clr_i` high at an edge zeroes `cyc_cnt_o`. This takes priority over a capture in the same cycle, and that capture is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Emulation running |
| cyc_i | input | 1 | Instruction-cycle strobe |
| pc_i | input | 12 | Program counter lines |
| data_i | input | 8 | Data bus lines |
| port_a_i | input | 8 | First I/O port lines |
| port_b_i | input | 8 | Second I/O port lines |
| stat_i | input | 8 | Status lines |
| cnt_clr_i | input | 1 | Host clear strobe for the cycle timer |
| rd_idx_i | input | 8 | Logical read index, 0 = oldest |
| rd_data_o | output | 44 | Record at the sampled index |
| rd_valid_o | output | 1 | Sampled index holds a record |
| fill_o | output | 8 | Number of held records |
| full_o | output | 1 | Store has wrapped at least once |
| cyc_cnt_o | output | 16 | Instruction-cycle timer |

## Verification
The timer clear and a capturing cycle can arrive at the same edge. The bench drives that coincidence with `run_i`, `cyc_i` and `cnt_clr_i` all high. It then expects the timer to read zero while `fill_o` still advances, and a later readout must return the record taken in that cycle. The bench also clears the timer in a cycle where capture is off. Clear alone and clear during capture are judged separately.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int PC_W   = 12;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] stat;
    logic [BYTE_W-1:0] port_b;
    logic [BYTE_W-1:0] port_a;
    logic [BYTE_W-1:0] data;
    logic [PC_W-1:0]   pc;
  } trace_rec_t;

  localparam int REC_W = $bits(trace_rec_t);
endpackage

// File: rtl/trace_wr_ctrl.sv
module trace_wr_ctrl #(
  parameter int DEPTH = 255,
  localparam int PW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  output logic [PW-1:0] wr_ptr_o,
  output logic [FW-1:0] fill_o,
  output logic          full_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [FW-1:0] FMAX = FW'(DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_o <= '0;
      fill_o   <= '0;
      full_o   <= 1'b0;
    end else if (push_i) begin
      if (wr_ptr_o == LAST) begin
        wr_ptr_o <= '0;
        full_o   <= 1'b1;
      end else begin
        wr_ptr_o <= wr_ptr_o + 1'b1;
      end
      if (fill_o != FMAX) fill_o <= fill_o + 1'b1;
    end
  end
endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int DEPTH = 255,
  parameter int W     = 44,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [PW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
    rd_data_o <= mem[rd_addr_i];  // read-before-write on collision
  end
endmodule

// File: rtl/trace_cyc_timer.sv
module trace_cyc_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_o <= '0;
    else if (clr_i)                   cnt_o <= '0;
    else if (tick_i && !(&cnt_o))     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cycle_trace_buf.sv
module cycle_trace_buf #(
  parameter int DEPTH = 255,
  parameter int CNT_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         run_i,
  input  logic                         cyc_i,
  input  logic [trace_pkg::PC_W-1:0]   pc_i,
  input  logic [trace_pkg::BYTE_W-1:0] data_i,
  input  logic [trace_pkg::BYTE_W-1:0] port_a_i,
  input  logic [trace_pkg::BYTE_W-1:0] port_b_i,
  input  logic [trace_pkg::BYTE_W-1:0] stat_i,
  input  logic                         cnt_clr_i,
  input  logic [$clog2(DEPTH+1)-1:0]   rd_idx_i,
  output logic [trace_pkg::REC_W-1:0]  rd_data_o,
  output logic                         rd_valid_o,
  output logic [$clog2(DEPTH+1)-1:0]   fill_o,
  output logic                         full_o,
  output logic [CNT_W-1:0]             cyc_cnt_o
);
  import trace_pkg::*;

  localparam int PW = $clog2(DEPTH);
  localparam int FW = $clog2(DEPTH + 1);
  localparam logic [FW:0] DEPTH_X = (FW+1)'(DEPTH);

  logic          push;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_addr;
  logic [FW:0]   base, sum, wrapped;
  trace_rec_t    rec;

  assign push = run_i & cyc_i;

  always_comb begin
    rec.pc     = pc_i;
    rec.data   = data_i;
    rec.port_a = port_a_i;
    rec.port_b = port_b_i;
    rec.stat   = stat_i;
  end

  trace_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .wr_ptr_o (wr_ptr),
    .fill_o   (fill_o),
    .full_o   (full_o)
  );

  // logical index -> physical slot; oldest sits at wr_ptr once wrapped
  always_comb begin
    base    = full_o ? (FW+1)'(wr_ptr) : '0;
    sum     = base + (FW+1)'(rd_idx_i);
    wrapped = (sum >= DEPTH_X) ? sum - DEPTH_X : sum;
    rd_addr = (wrapped < DEPTH_X) ? PW'(wrapped) : '0;
  end

  trace_store #(.DEPTH(DEPTH), .W(REC_W)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (push),
    .wr_addr_i (wr_ptr),
    .wr_data_i (rec),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_o <= 1'b0;
    else         rd_valid_o <= (rd_idx_i < fill_o);
  end

  trace_cyc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (push),
    .clr_i  (cnt_clr_i),
    .cnt_o  (cyc_cnt_o)
  );
endmodule

// File: rtl/cycle_trace_buf_chk.sv
module cycle_trace_buf_chk #(
  parameter int DEPTH = 255,
  parameter int CNT_W = 16,
  localparam int FW = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             cyc_i,
  input logic             cnt_clr_i,
  input logic [FW-1:0]    rd_idx_i,
  input logic             rd_valid_o,
  input logic [FW-1:0]    fill_o,
  input logic             full_o,
  input logic [CNT_W-1:0] cyc_cnt_o
);
  localparam logic [FW-1:0]    FMAX = FW'(DEPTH);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> full_o); // R4
  AST_FULL_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> fill_o == FMAX); // R4
  AST_HALT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && cyc_i) |=> $stable(fill_o) && $stable(full_o)); // R3
  AST_FILL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cyc_i && fill_o != FMAX) |=> fill_o == FW'($past(fill_o) + 1'b1)); // R2
  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> cyc_cnt_o == '0); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cyc_i && !cnt_clr_i && cyc_cnt_o != CMAX)
      |=> cyc_cnt_o == CNT_W'($past(cyc_cnt_o) + 1'b1)); // R8
  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_cnt_o == CMAX && !cnt_clr_i) |=> cyc_cnt_o == CMAX); // R8
  AST_VALID_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_idx_i) < $past(fill_o)); // R7
endmodule

bind cycle_trace_buf cycle_trace_buf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_i      (run_i),
  .cyc_i      (cyc_i),
  .cnt_clr_i  (cnt_clr_i),
  .rd_idx_i   (rd_idx_i),
  .rd_valid_o (rd_valid_o),
  .fill_o     (fill_o),
  .full_o     (full_o),
  .cyc_cnt_o  (cyc_cnt_o)
);

// File: tb/sim_cycle_trace_buf.sv
`timescale 1ns/1ps
module sim_cycle_trace_buf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0, cyc_i = 1'b0, cnt_clr_i = 1'b0;
  logic [11:0] pc_i = '0;
  logic [7:0]  data_i = '0, port_a_i = '0, port_b_i = '0, stat_i = '0;
  logic [7:0]  rd_idx_i = '0;
  logic [43:0] rd_data_o;
  logic        rd_valid_o, full_o;
  logic [7:0]  fill_o;
  logic [15:0] cyc_cnt_o;

  int total = 0, bad = 0, wn = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  cycle_trace_buf u0 (.*);

  // record layout per R2: {stat, port_b, port_a, data, pc}
  function automatic logic [43:0] ent(int w);
    logic [11:0] pc = 12'(w * 37 + 5);
    logic [7:0]  d  = 8'(w ^ 'h5a);
    logic [7:0]  a  = 8'(w * 3 + 1);
    logic [7:0]  b  = 8'(~w);
    logic [7:0]  s  = 8'((w >> 1) ^ 'h33);
    return {s, b, a, d, pc};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit run, bit cyc, bit clr);
    run_i = run; cyc_i = cyc; cnt_clr_i = clr;
    {stat_i, port_b_i, port_a_i, data_i, pc_i} = ent(wn);
    @(posedge clk_i); #1;
    if (run && cyc) wn++;
    cnt_clr_i = 1'b0;
  endtask

  task automatic rd(int idx, bit exp_v, logic [43:0] exp_d, string tag);
    rd_idx_i = 8'(idx);
    @(posedge clk_i); #1;
    chk(rd_valid_o == exp_v, {tag, " valid"}, 64'(rd_valid_o), 64'(exp_v));
    if (exp_v) chk(rd_data_o == exp_d, {tag, " data"}, 64'(rd_data_o), 64'(exp_d));
  endtask

  typedef struct packed {
    logic        run;
    logic        cyc;
    logic        clr;
    logic [15:0] cnt;
    logic [7:0]  fill;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b1, 1'b0, 16'd1, 8'd1},  // R8 capture counts
    '{1'b1, 1'b0, 1'b0, 16'd1, 8'd1},  // R3 no strobe
    '{1'b0, 1'b1, 1'b0, 16'd1, 8'd1},  // R3 halted
    '{1'b1, 1'b1, 1'b0, 16'd2, 8'd2},  // R2
    '{1'b1, 1'b1, 1'b1, 16'd0, 8'd3},  // R9 clear beats capture, record kept
    '{1'b0, 1'b0, 1'b1, 16'd0, 8'd3},  // R9 clear alone
    '{1'b1, 1'b1, 1'b0, 16'd1, 8'd4},  // R8
    '{1'b0, 1'b1, 1'b1, 16'd0, 8'd4}   // R9 / R3
  };

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #12 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R1 reset state
    chk(fill_o == 0, "R1 fill", 64'(fill_o), 0);
    chk(full_o == 0, "R1 full", 64'(full_o), 0);
    chk(cyc_cnt_o == 0, "R1 cnt", 64'(cyc_cnt_o), 0);
    chk(rd_valid_o == 0, "R1 valid", 64'(rd_valid_o), 0);

    foreach (VEC[i]) begin
      step(VEC[i].run, VEC[i].cyc, VEC[i].clr);
      chk(cyc_cnt_o == VEC[i].cnt, "R8/R9 vec cnt", 64'(cyc_cnt_o), 64'(VEC[i].cnt));
      chk(fill_o == VEC[i].fill, "R2/R3 vec fill", 64'(fill_o), 64'(VEC[i].fill));
    end

    // R3: halted with changing lines, store untouched
    run_i = 1'b0; cyc_i = 1'b1;
    {stat_i, port_b_i, port_a_i, data_i, pc_i} = '1;
    repeat (3) @(posedge clk_i);
    #1;
    chk(fill_o == 4, "R3 frozen fill", 64'(fill_o), 4);
    cyc_i = 1'b0;

    // R2/R5 readback before wrap; record 2 was captured with clear high
    for (int k = 0; k < 4; k++) rd(k, 1'b1, ent(k), "R2/R5 pre-wrap");
    rd(4, 1'b0, '0, "R7 beyond fill");

    // R6: output holds until the next edge after an index change
    rd_idx_i = 8'd1;
    #1;
    chk(rd_valid_o == 0, "R6 latency", 64'(rd_valid_o), 0);
    @(posedge clk_i); #1;
    chk(rd_data_o == ent(1), "R6 after edge", 64'(rd_data_o), 64'(ent(1)));

    // R4: fill to 254, then to 255
    repeat (250) step(1, 1, 0);
    chk(fill_o == 254 && full_o == 0, "R4 before wrap", {fill_o, 7'd0, full_o}, {8'd254, 8'd0});
    step(1, 1, 0);
    chk(full_o == 1, "R4 full set", 64'(full_o), 1);
    chk(fill_o == 255, "R4 fill max", 64'(fill_o), 255);
    repeat (10) step(1, 1, 0);
    run_i = 1'b0;
    chk(full_o == 1 && fill_o == 255, "R4 sticky", {fill_o, 7'd0, full_o}, {8'd255, 8'd1});

    // R5 after wrap: oldest is write wn-255
    rd(0, 1'b1, ent(wn - 255), "R5 oldest");
    rd(100, 1'b1, ent(wn - 155), "R5 middle");
    rd(254, 1'b1, ent(wn - 1), "R5 newest");
    rd(255, 1'b0, '0, "R7 index 255");

    // R8 saturation
    repeat (65540) step(1, 1, 0);
    chk(cyc_cnt_o == 16'hffff, "R8 saturate", 64'(cyc_cnt_o), 64'hffff);
    step(0, 0, 1);
    chk(cyc_cnt_o == 0, "R9 clear after sat", 64'(cyc_cnt_o), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule